// File: doc/BRIEF.md
# Serial Link Receiver Power and Lock Sequencer

This block decides which power and lock state a serial-link receiver is in. It watches four things: a power-enable pin (low means power down), an auto-detect strap, a per-word report of whether the embedded clock bits arrived, and the lock flag of an external clock-recovery loop. From these it drives a lock status flag with its own output enable, a pair of controls that force the parallel data, sync and pixel-clock outputs low or to high impedance while the link is not locked, and two controls for the configuration register file. One control is a reset pulse. The other is a retain level.

There are two low-power states. Explicit power-down clears the configuration. Stream-stop sleep keeps it. With auto-detect set and the pin held high, a stopped stream sends the block to power-down instead of sleep. In either case the block wakes again by itself once the stream returns. Stream loss and stream return are both filtered over several word slots. The recovery loop's lock must be stable for a fixed number of cycles before the block reports lock.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While reset is applied, and on the clock edge after `pwr_en_i` is sampled low, the state is power-down: `state_o` = 0, `lock_oe_o` = 0, `lock_o` = 0.
- R2: `cfg_rst_o` is high for exactly the one cycle that follows each entry into power-down. At every other time it is low, including during and straight after reset.
- R3: In power-down, with `pwr_en_i` high and `auto_det_i` low, the next edge moves the state to acquiring (`state_o` = 1). In that state `lock_oe_o` = 1 and `lock_o` = 0.
- R4: From acquiring, the state becomes locked (`state_o` = 2, `lock_o` = 1) on the 17th consecutive edge at which `cdr_lock_i` is high, and not earlier. If `cdr_lock_i` is sampled low while locked, the state returns to acquiring two edges later.
- R5: A stream that is up is declared stopped at the 8th consecutive slot (an edge with `word_vld_i` high) that has `clk_bits_ok_i` low. The state responds on the following edge. Seven such slots have no effect.
- R6: A stream stop seen while acquiring or locked, with `auto_det_i` low, leads to sleep (`state_o` = 3). In sleep `cfg_keep_o` = 1, `lock_oe_o` = 1, `lock_o` = 0, and no `cfg_rst_o` pulse is issued.
- R7: A stream stop seen while acquiring or locked, with `auto_det_i` high, leads to power-down, with a `cfg_rst_o` pulse and `lock_oe_o` = 0.
- R8: The stream counts as restarted at the 4th consecutive slot with `clk_bits_ok_i` high. On the next edge, sleep, or power-down with `pwr_en_i` high and `auto_det_i` high, moves to acquiring. Auto power-down holds while the stream stays absent.
- R9: Edges with `word_vld_i` low neither count toward a run of slots nor break one.
- R10: The selected output state is `oss_ovr_val_i` when `oss_ovr_en_i` = 1, otherwise `oss_strap_i`. In every state except locked, `out_low_o` = not selected and `out_hiz_o` = selected. In locked, both are 0. Both outputs follow their inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en_i | input | 1 | Power enable pin; low forces power-down |
| auto_det_i | input | 1 | Auto-detect strap: a stream stop leads to power-down instead of sleep |
| word_vld_i | input | 1 | One received word slot this cycle |
| clk_bits_ok_i | input | 1 | Embedded clock bits present in this slot |
| cdr_lock_i | input | 1 | Lock flag from the clock-recovery loop |
| oss_strap_i | input | 1 | Output state strap: 0 = drive low, 1 = high impedance |
| oss_ovr_en_i | input | 1 | Register override enable for the output state |
| oss_ovr_val_i | input | 1 | Register override value for the output state |
| state_o | output | 2 | 0 power-down, 1 acquiring, 2 locked, 3 sleep |
| lock_o | output | 1 | Lock status value |
| lock_oe_o | output | 1 | Output enable for the lock pin |
| out_low_o | output | 1 | Force parallel and pixel-clock outputs low |
| out_hiz_o | output | 1 | Put parallel and pixel-clock outputs in high impedance |
| cfg_rst_o | output | 1 | One-cycle configuration register reset |
| cfg_keep_o | output | 1 | Configuration registers to retain contents |

## Verification
The hardest situation to reach is the wake-up from auto power-down. It needs the pin held high and auto-detect set. A full lock must first be reached, then lost through eight bad slots, and the block must then sit idle in power-down before a four-slot restart. The stimulus table walks through this chain in order. Directed sequences then check the exact edges of each filter: 16 versus 17 lock cycles, 8 versus 9 bad slots, and a restart run split by gaps with `word_vld_i` low.

// File: rtl/link_pwr_pkg.sv
package link_pwr_pkg;

    typedef enum logic [1:0] {
        ST_PWRDN  = 2'd0,
        ST_ACQ    = 2'd1,
        ST_LOCKED = 2'd2,
        ST_SLEEP  = 2'd3
    } pwr_state_e;

endpackage

// File: rtl/link_stream_mon.sv
module link_stream_mon #(
    parameter int STOP_SLOTS  = 8,
    parameter int START_SLOTS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_vld_i,
    input  logic bits_ok_i,
    output logic stream_up_o,
    output logic stop_evt_o
);

    localparam int BW = $clog2(STOP_SLOTS + 1);
    localparam int GW = $clog2(START_SLOTS + 1);
    localparam logic [BW-1:0] BAD_SAT   = BW'(STOP_SLOTS);
    localparam logic [BW-1:0] BAD_LAST  = BW'(STOP_SLOTS - 1);
    localparam logic [GW-1:0] GOOD_SAT  = GW'(START_SLOTS);
    localparam logic [GW-1:0] GOOD_LAST = GW'(START_SLOTS - 1);

    typedef struct packed {
        logic [BW-1:0] bad;
        logic [GW-1:0] good;
        logic          up;
        logic          stop;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d      = mon_q;
        mon_d.stop = 1'b0;
        if (slot_vld_i) begin
            if (bits_ok_i) begin
                mon_d.bad = '0;
                if (mon_q.good != GOOD_SAT) mon_d.good = mon_q.good + 1'b1;
                if (mon_q.good == GOOD_LAST) mon_d.up = 1'b1;
            end else begin
                mon_d.good = '0;
                if (mon_q.bad != BAD_SAT) mon_d.bad = mon_q.bad + 1'b1;
                if (mon_q.bad == BAD_LAST && mon_q.up) begin
                    mon_d.up   = 1'b0;
                    mon_d.stop = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign stream_up_o = mon_q.up;
    assign stop_evt_o  = mon_q.stop;

endmodule

// File: rtl/link_lock_qual.sv
module link_lock_qual #(
    parameter int LOCK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cdr_lock_i,
    output logic lock_ok_o
);

    localparam int CW = $clog2(LOCK_CYC + 1);
    localparam logic [CW-1:0] CNT_SAT = CW'(LOCK_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t qual_d, qual_q;

    always_comb begin
        qual_d = qual_q;
        if (!cdr_lock_i)                 qual_d.cnt = '0;
        else if (qual_q.cnt != CNT_SAT)  qual_d.cnt = qual_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qual_q <= '0;
        else        qual_q <= qual_d;
    end

    assign lock_ok_o = (qual_q.cnt == CNT_SAT);

endmodule

// File: rtl/link_pwr_fsm.sv
module link_pwr_fsm
    import link_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_en_i,
    input  logic       auto_det_i,
    input  logic       stream_up_i,
    input  logic       stop_evt_i,
    input  logic       lock_ok_i,
    output pwr_state_e state_o,
    output logic       cfg_rst_o
);

    typedef struct packed {
        pwr_state_e st;
        logic       cfg_rst;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_PWRDN: begin
                if (pwr_en_i && (!auto_det_i || stream_up_i)) fsm_d.st = ST_ACQ;
            end
            ST_ACQ: begin
                if (stop_evt_i)     fsm_d.st = auto_det_i ? ST_PWRDN : ST_SLEEP;
                else if (lock_ok_i) fsm_d.st = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (stop_evt_i)      fsm_d.st = auto_det_i ? ST_PWRDN : ST_SLEEP;
                else if (!lock_ok_i) fsm_d.st = ST_ACQ;
            end
            ST_SLEEP: begin
                if (stream_up_i) fsm_d.st = ST_ACQ;
            end
            default: fsm_d.st = ST_PWRDN;
        endcase
        if (!pwr_en_i) fsm_d.st = ST_PWRDN;
        fsm_d.cfg_rst = (fsm_d.st == ST_PWRDN) && (fsm_q.st != ST_PWRDN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st      <= ST_PWRDN;
            fsm_q.cfg_rst <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o   = fsm_q.st;
    assign cfg_rst_o = fsm_q.cfg_rst;

endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
    import link_pwr_pkg::*;
#(
    parameter int STOP_SLOTS  = 8,
    parameter int START_SLOTS = 4,
    parameter int LOCK_CYC    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_en_i,
    input  logic       auto_det_i,
    input  logic       word_vld_i,
    input  logic       clk_bits_ok_i,
    input  logic       cdr_lock_i,
    input  logic       oss_strap_i,
    input  logic       oss_ovr_en_i,
    input  logic       oss_ovr_val_i,
    output logic [1:0] state_o,
    output logic       lock_o,
    output logic       lock_oe_o,
    output logic       out_low_o,
    output logic       out_hiz_o,
    output logic       cfg_rst_o,
    output logic       cfg_keep_o
);

    logic       stream_up;
    logic       stop_evt;
    logic       lock_ok;
    pwr_state_e cur_st;
    logic       oss_sel;
    logic       force_out;

    link_stream_mon #(
        .STOP_SLOTS (STOP_SLOTS),
        .START_SLOTS(START_SLOTS)
    ) i_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_vld_i (word_vld_i),
        .bits_ok_i  (clk_bits_ok_i),
        .stream_up_o(stream_up),
        .stop_evt_o (stop_evt)
    );

    link_lock_qual #(
        .LOCK_CYC(LOCK_CYC)
    ) i_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .cdr_lock_i(cdr_lock_i),
        .lock_ok_o (lock_ok)
    );

    link_pwr_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_en_i   (pwr_en_i),
        .auto_det_i (auto_det_i),
        .stream_up_i(stream_up),
        .stop_evt_i (stop_evt),
        .lock_ok_i  (lock_ok),
        .state_o    (cur_st),
        .cfg_rst_o  (cfg_rst_o)
    );

    always_comb begin
        oss_sel    = oss_ovr_en_i ? oss_ovr_val_i : oss_strap_i;
        force_out  = (cur_st != ST_LOCKED);
        state_o    = cur_st;
        lock_o     = (cur_st == ST_LOCKED);
        lock_oe_o  = (cur_st != ST_PWRDN);
        cfg_keep_o = (cur_st == ST_SLEEP);
        out_low_o  = force_out && !oss_sel;
        out_hiz_o  = force_out && oss_sel;
    end

endmodule

// File: rtl/link_pwr_ctrl_chk.sv
module link_pwr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_en_i,
    input logic       auto_det_i,
    input logic       cdr_lock_i,
    input logic [1:0] state_o,
    input logic       lock_o,
    input logic       lock_oe_o,
    input logic       out_low_o,
    input logic       out_hiz_o,
    input logic       cfg_rst_o
);

    // R1
    pin_pwrdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en_i |=> (state_o == 2'd0 && !lock_oe_o && !lock_o));

    // R2
    cfg_rst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst_o |-> (state_o == 2'd0 && $past(state_o) != 2'd0));

    // R4
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> ($past(cdr_lock_i) && lock_oe_o));

    // R6
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && $past(state_o) != 2'd3) |-> (!$past(auto_det_i) && !cfg_rst_o));

    // R10
    out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_low_o, out_hiz_o}));

    // R10
    locked_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> (!out_low_o && !out_hiz_o));

endmodule

bind link_pwr_ctrl link_pwr_ctrl_chk i_link_pwr_ctrl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_en_i  (pwr_en_i),
    .auto_det_i(auto_det_i),
    .cdr_lock_i(cdr_lock_i),
    .state_o   (state_o),
    .lock_o    (lock_o),
    .lock_oe_o (lock_oe_o),
    .out_low_o (out_low_o),
    .out_hiz_o (out_hiz_o),
    .cfg_rst_o (cfg_rst_o)
);

// File: tb/test_link_pwr_ctrl.sv
module test_link_pwr_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_en = 1'b0;
    logic       auto_det = 1'b0;
    logic       word_vld = 1'b1;
    logic       bits_ok = 1'b0;
    logic       cdr_lock = 1'b0;
    logic       oss_strap = 1'b0;
    logic       oss_ovr_en = 1'b0;
    logic       oss_ovr_val = 1'b0;
    logic [1:0] state;
    logic       lock, lock_oe, out_low, out_hiz, cfg_rst, cfg_keep;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    link_pwr_ctrl i_link_pwr_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_en_i     (pwr_en),
        .auto_det_i   (auto_det),
        .word_vld_i   (word_vld),
        .clk_bits_ok_i(bits_ok),
        .cdr_lock_i   (cdr_lock),
        .oss_strap_i  (oss_strap),
        .oss_ovr_en_i (oss_ovr_en),
        .oss_ovr_val_i(oss_ovr_val),
        .state_o      (state),
        .lock_o       (lock),
        .lock_oe_o    (lock_oe),
        .out_low_o    (out_low),
        .out_hiz_o    (out_hiz),
        .cfg_rst_o    (cfg_rst),
        .cfg_keep_o   (cfg_keep)
    );

    // {pwr, auto, bits_ok, cdr, cycles[7:0], state[1:0], lock, lock_oe}
    localparam logic [15:0] VECS [0:10] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd3,  2'd0, 1'b0, 1'b0},  // R1
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd1,  2'd1, 1'b0, 1'b1},  // R3
        {1'b1, 1'b0, 1'b1, 1'b1, 8'd17, 2'd2, 1'b1, 1'b1},  // R4
        {1'b1, 1'b0, 1'b0, 1'b1, 8'd9,  2'd3, 1'b0, 1'b1},  // R5 R6
        {1'b1, 1'b0, 1'b1, 1'b1, 8'd5,  2'd1, 1'b0, 1'b1},  // R8
        {1'b1, 1'b0, 1'b1, 1'b1, 8'd1,  2'd2, 1'b1, 1'b1},  // R4
        {1'b1, 1'b1, 1'b0, 1'b1, 8'd9,  2'd0, 1'b0, 1'b0},  // R7
        {1'b1, 1'b1, 1'b1, 1'b1, 8'd5,  2'd1, 1'b0, 1'b1},  // R8
        {1'b1, 1'b1, 1'b1, 1'b1, 8'd1,  2'd2, 1'b1, 1'b1},  // R4
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd2,  2'd1, 1'b0, 1'b1},  // R4
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd1,  2'd0, 1'b0, 1'b0}   // R1
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // reset state R1 R2
        repeat (2) @(negedge clk);
        check("R1 reset state", state, 0);
        check("R1 reset lock_oe", lock_oe, 0);
        check("R2 reset cfg_rst", cfg_rst, 0);
        rst_n = 1'b1;
        step(1);
        check("R2 after reset cfg_rst", cfg_rst, 0);

        for (int i = 0; i < 11; i++) begin
            pwr_en   = VECS[i][15];
            auto_det = VECS[i][14];
            bits_ok  = VECS[i][13];
            cdr_lock = VECS[i][12];
            step(int'(VECS[i][11:4]));
            check($sformatf("R1-table vec %0d state", i), state, int'(VECS[i][3:2]));
            check($sformatf("R4 table vec %0d lock", i), lock, int'(VECS[i][1]));
            check($sformatf("R3 table vec %0d lock_oe", i), lock_oe, int'(VECS[i][0]));
        end

        // R2: pulse after entering power-down, then low
        check("R2 pulse on entry", cfg_rst, 1);
        step(1);
        check("R2 pulse one cycle", cfg_rst, 0);

        // R4: lock boundary 16 vs 17
        auto_det = 1'b0; pwr_en = 1'b1; bits_ok = 1'b1; cdr_lock = 1'b0;
        step(2);
        check("R3 acquiring", state, 1);
        cdr_lock = 1'b1;
        step(16);
        check("R4 not yet locked at 16", state, 1);
        step(1);
        check("R4 locked at 17", state, 2);

        // R5/R6: stop boundary
        bits_ok = 1'b0;
        step(8);
        check("R5 still locked after 8 bad", state, 2);
        step(1);
        check("R5 sleep after stop", state, 3);
        check("R6 keep in sleep", cfg_keep, 1);
        check("R6 no cfg reset", cfg_rst, 0);
        check("R6 lock_oe in sleep", lock_oe, 1);

        // R9: gaps neither count nor break
        word_vld = 1'b0; bits_ok = 1'b1;
        step(10);
        check("R9 idle slots ignored", state, 3);
        word_vld = 1'b1;
        step(3);
        word_vld = 1'b0;
        step(5);
        word_vld = 1'b1;
        step(1);
        check("R9 fourth slot across gap", state, 3);
        step(1);
        check("R8 R9 restart to acquiring", state, 1);
        step(1);
        check("R4 relock with stable cdr", state, 2);

        // R10: output state select
        cdr_lock = 1'b0;
        step(2);
        check("R10 unlocked state", state, 1);
        oss_strap = 1'b0; oss_ovr_en = 1'b0; #1;
        check("R10 strap0 low", out_low, 1);
        check("R10 strap0 hiz", out_hiz, 0);
        oss_strap = 1'b1; #1;
        check("R10 strap1 hiz", out_hiz, 1);
        check("R10 strap1 low", out_low, 0);
        oss_ovr_en = 1'b1; oss_ovr_val = 1'b0; #1;
        check("R10 override low", out_low, 1);
        oss_strap = 1'b0; oss_ovr_val = 1'b1; #1;
        check("R10 override hiz", out_hiz, 1);
        @(negedge clk);
        cdr_lock = 1'b1;
        step(17);
        check("R10 locked lock", lock, 1);
        check("R10 locked no force", {out_low, out_hiz}, 0);

        // R7/R8: auto power-down holds while stream absent
        auto_det = 1'b1; bits_ok = 1'b0;
        step(9);
        check("R7 auto power-down", state, 0);
        check("R7 cfg reset pulse", cfg_rst, 1);
        step(20);
        check("R8 holds in auto power-down", state, 0);
        check("R7 lock_oe off", lock_oe, 0);
        bits_ok = 1'b1;
        step(4);
        check("R8 not before restart seen", state, 0);
        step(1);
        check("R8 wake from auto power-down", state, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule